// File: doc/BRIEF.md
# Pin-Controlled Down-Counter Timer

This block is a programmable down-counter whose progress can be steered by a single input pin. The pin can serve four purposes. It can be a count clock, where every falling edge takes one off the count. It can be a gate, where prescaled internal ticks are counted only while the pin is high. It can be a one-shot trigger, or a trigger that restarts a count already under way. In both trigger functions the starting value is copied into the counter by the trigger itself. In the clock and gate functions, and when the pin is switched out, software starts a count by setting a load bit.

Software reaches the block through a small write port with four registers:

| Address | Register | Fields |
| --- | --- | --- |
| 0 | mode | pin function in bits 5:4, count enable in bit 3, load bit in bit 2 |
| 1 | configuration | external source select in bit 2, pin disable in bit 1, continuous in bit 0 |
| 2 | start value | the whole byte |
| 3 | divide | prescaler divisor in bits 7:2 |

The outputs are the live count value and a one-cycle end-of-count pulse, meant for an interrupt controller.

Top module: `pinTimer`

## Requirements
- R1: After reset the count reads 0, the end-of-count pulse is low, and the timer does not count until it is set up again.
- R2: Writing the mode register with bit 2 set copies the start value into the counter on the following clock edge. The load bit then clears itself, so a later write of a new start value leaves the count unchanged.
- R3: The counter decrements only while the enable bit (mode bit 3) is 1. With the bit at 0 the count holds.
- R4: In pin-clock function (mode bits 5:4 = 00, configuration bit 2 = 1, configuration bit 1 = 0), the pin passes through a two-flop synchronizer. Each high-to-low transition lowers the count by exactly one, on the third rising clock edge after the pin falls. Rising transitions do nothing.
- R5: In gate function (mode bits 5:4 = 01, pin active as in R4), the counter decrements once per prescaler tick while the synchronized pin is high, and holds while it is low.
- R6: The prescaler produces one tick every N clocks, where N is the divide-register field in bits 7:2 and a value of 0 means 64. Writing the divide register restarts the prescaler phase.
- R7: A decrement taken at a count of 1 (or 0) raises the end-of-count output for exactly one cycle and leaves the count at 0. The timer then stops unless R8 applies.
- R8: In the clock, gate and pin-disabled cases, when continuous mode (configuration bit 0) is 1, reaching the end reloads the start value in the same edge and counting goes on.
- R9: In one-shot trigger function (mode bits 5:4 = 10, pin active), a pin falling edge with the enable bit set loads the start value and starts the count. A falling edge during a running count is ignored, and so is the load bit.
- R10: In restartable trigger function (mode bits 5:4 = 11, pin active), a falling edge during a running count reloads the start value.
- R11: When configuration bit 1 is 1 or bit 2 is 0, the pin has no effect. The timer then counts prescaled ticks after a software load, whatever the pin-function field holds.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 mode, 1 configuration, 2 start value, 3 divide |
| wrData | input | 8 | Write data |
| pinIn | input | 1 | Asynchronous control pin |
| count | output | 8 | Current counter value |
| eoc | output | 1 | One-cycle end-of-count pulse |

## Verification
A software load shows on the count one edge after the mode write. Register writes in the bench are issued back to back, one per edge, so the prescaler phase is known exactly from the divide write onward. Each table entry's expected value is worked out as the number of tick edges between the load edge and the sampling edge. Pin events take three edges to move the count, so the bench samples two cycles after a pin change to confirm nothing has happened yet and one cycle later to see the step. End-of-count and reload checks are sampled in the single cycle where the pulse is high and again in the cycle after it.

// File: rtl/tmrPkg.sv
`timescale 1ns/1ps
package tmrPkg;
  typedef enum logic [1:0] {
    PIN_CLOCK  = 2'b00,
    PIN_GATE   = 2'b01,
    PIN_TRIG   = 2'b10,
    PIN_RETRIG = 2'b11
  } pinFunc_e;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_CFG  = 2'd1;
  localparam logic [1:0] ADDR_INIT = 2'd2;
  localparam logic [1:0] ADDR_DIV  = 2'd3;

  typedef struct packed {
    logic load;
    logic dec;
    logic wrapReload;
  } cntStrobe_t;
endpackage

// File: rtl/tmrCtrl.sv
`timescale 1ns/1ps
module tmrCtrl
  import tmrPkg::*;
#(
  parameter int DW     = 8,
  parameter int PRE_W  = 6,
  parameter int SYNC_N = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [1:0]    wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic          pinIn,
  input  logic          atLast,
  output logic [DW-1:0] initVal,
  output cntStrobe_t    strobe
);
  localparam logic [PRE_W:0] DIV_MAX = {1'b1, {PRE_W{1'b0}}};

  pinFunc_e         pinFunc;
  logic             cntEnable, loadReq;
  logic             srcExt, pinOff, contMode;
  logic [PRE_W-1:0] divSel, preCnt;
  logic [SYNC_N-1:0] syncQ;
  logic             pinSync, pinPrev, fallEdge;
  logic             running, tick, step, loadNow;
  logic             pinActive, trigMode;
  logic [PRE_W:0]   divN;

  // register write port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinFunc   <= PIN_CLOCK;
      cntEnable <= 1'b0;
      loadReq   <= 1'b0;
      srcExt    <= 1'b0;
      pinOff    <= 1'b0;
      contMode  <= 1'b0;
      divSel    <= '0;
      initVal   <= '0;
    end else begin
      loadReq <= 1'b0;
      if (wrEn) begin
        case (wrAddr)
          ADDR_MODE: begin
            pinFunc   <= pinFunc_e'(wrData[5:4]);
            cntEnable <= wrData[3];
            loadReq   <= wrData[2];
          end
          ADDR_CFG: begin
            srcExt   <= wrData[2];
            pinOff   <= wrData[1];
            contMode <= wrData[0];
          end
          ADDR_INIT: initVal <= wrData;
          default:   divSel  <= wrData[DW-1 -: PRE_W];
        endcase
      end
    end
  end

  // pin synchronizer and falling-edge detector
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '0;
      pinPrev <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_N-2:0], pinIn};
      pinPrev <= pinSync;
    end
  end
  assign pinSync  = syncQ[SYNC_N-1];
  assign fallEdge = pinPrev & ~pinSync;

  // prescaler
  assign divN = (divSel == '0) ? DIV_MAX : {1'b0, divSel};
  assign tick = ({1'b0, preCnt} == (divN - 1'b1));

  always_ff @(posedge clk) begin
    if (!rstN) preCnt <= '0;
    else if (wrEn && wrAddr == ADDR_DIV) preCnt <= '0;
    else if (tick) preCnt <= '0;
    else preCnt <= preCnt + 1'b1;
  end

  // mode decode
  assign pinActive = srcExt & ~pinOff;
  assign trigMode  = pinActive & pinFunc[1];

  always_comb begin
    if (!pinActive) step = tick;
    else begin
      case (pinFunc)
        PIN_CLOCK: step = fallEdge;
        PIN_GATE:  step = tick & pinSync;
        default:   step = tick;
      endcase
    end
  end

  assign loadNow = trigMode
                 ? (cntEnable & fallEdge & (~running | (pinFunc == PIN_RETRIG)))
                 : loadReq;

  assign strobe.load       = loadNow;
  assign strobe.dec        = cntEnable & running & step & ~loadNow;
  assign strobe.wrapReload = contMode & ~trigMode;

  always_ff @(posedge clk) begin
    if (!rstN) running <= 1'b0;
    else if (loadNow) running <= 1'b1;
    else if (strobe.dec && atLast) running <= strobe.wrapReload;
  end

  // R2
  load_selfclear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadReq && !(wrEn && wrAddr == ADDR_MODE)) |=> !loadReq);

  // R3
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cntEnable |-> !strobe.dec);

  // R9
  no_retrig_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trigMode && pinFunc == PIN_TRIG && running) |-> !strobe.load);
endmodule

// File: rtl/tmrData.sv
`timescale 1ns/1ps
module tmrData
  import tmrPkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  cntStrobe_t    strobe,
  input  logic [DW-1:0] initVal,
  output logic [DW-1:0] count,
  output logic          eoc,
  output logic          atLast
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  assign atLast = (count <= ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      eoc   <= 1'b0;
    end else begin
      eoc <= strobe.dec & atLast;
      if (strobe.load) count <= initVal;
      else if (strobe.dec) begin
        if (atLast) count <= strobe.wrapReload ? initVal : '0;
        else count <= count - 1'b1;
      end
    end
  end

  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.dec) |=> $stable(count));

  // R4
  dec_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dec && !strobe.load && !atLast) |=> (count == $past(count) - ONE));

  // R7
  count_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dec && !strobe.load && atLast && !strobe.wrapReload) |=> (count == '0 && eoc));
endmodule

// File: rtl/pinTimer.sv
`timescale 1ns/1ps
module pinTimer
  import tmrPkg::*;
#(
  parameter int DW     = 8,
  parameter int PRE_W  = 6,
  parameter int SYNC_N = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [1:0]    wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic          pinIn,
  output logic [DW-1:0] count,
  output logic          eoc
);
  cntStrobe_t    strobe;
  logic [DW-1:0] initVal;
  logic          atLast;

  tmrCtrl #(.DW(DW), .PRE_W(PRE_W), .SYNC_N(SYNC_N)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pinIn(pinIn), .atLast(atLast), .initVal(initVal), .strobe(strobe)
  );

  tmrData #(.DW(DW)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .initVal(initVal),
    .count(count), .eoc(eoc), .atLast(atLast)
  );
endmodule

// File: tb/test_pinTimer.sv
`timescale 1ns/1ps
module test_pinTimer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic       pinIn = 1'b0;
  logic [7:0] count;
  logic       eoc;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  pinTimer i_pinTimer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pinIn(pinIn), .count(count), .eoc(eoc)
  );

  // prescaler table (R6): divide field, cycles waited after the mode write, expected count
  localparam int NVEC = 6;
  localparam int VEC [NVEC][3] = '{
    '{1, 10, 191}, '{4, 10, 197}, '{3, 20, 194},
    '{0, 70, 199}, '{5, 30, 194}, '{2, 7, 197}
  };

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: got %0d, expected %0d", tag, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next rising edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got 0, expected 1");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    doReset();
    chk("R1 count", int'(count), 0);
    chk("R1 eoc", int'(eoc), 0);
    wr(2'd0, 8'h08);
    repeat (5) @(negedge clk);
    chk("R1 idle", int'(count), 0);

    // R6 table walk, internal source
    wr(2'd1, 8'h00);
    for (int i = 0; i < NVEC; i++) begin
      wr(2'd0, 8'h00);
      wr(2'd3, 8'(VEC[i][0] << 2));
      wr(2'd2, 8'd200);
      wr(2'd0, 8'h0C);
      repeat (VEC[i][1]) @(negedge clk);
      chk("R6 prescaled count", int'(count), VEC[i][2]);
    end

    // R2 / R3 load and enable
    doReset();
    wr(2'd1, 8'h00);
    wr(2'd3, 8'd1 << 2);
    wr(2'd2, 8'd50);
    wr(2'd0, 8'h04);
    chk("R2 loaded", int'(count), 0);
    @(negedge clk);
    chk("R2 loaded", int'(count), 50);
    wr(2'd2, 8'd77);
    repeat (3) @(negedge clk);
    chk("R2 no second load", int'(count), 50);
    wr(2'd0, 8'h08);
    repeat (5) @(negedge clk);
    chk("R3 counting", int'(count), 45);
    wr(2'd0, 8'h00);
    repeat (5) @(negedge clk);
    chk("R3 hold", int'(count), 44);

    // R7 one-shot end of count
    wr(2'd2, 8'd3);
    wr(2'd0, 8'h0C);
    @(negedge clk);
    chk("R7 start", int'(count), 3);
    repeat (2) @(negedge clk);
    chk("R7 last", int'(count), 1);
    chk("R7 eoc low", int'(eoc), 0);
    @(negedge clk);
    chk("R7 end count", int'(count), 0);
    chk("R7 eoc high", int'(eoc), 1);
    @(negedge clk);
    chk("R7 eoc one cycle", int'(eoc), 0);
    repeat (5) @(negedge clk);
    chk("R7 stopped", int'(count), 0);

    // R8 continuous reload
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h0C);
    @(negedge clk);
    chk("R8 start", int'(count), 3);
    repeat (3) @(negedge clk);
    chk("R8 reload", int'(count), 3);
    chk("R8 eoc", int'(eoc), 1);
    @(negedge clk);
    chk("R8 running", int'(count), 2);
    chk("R8 eoc low", int'(eoc), 0);
    repeat (2) @(negedge clk);
    chk("R8 second reload", int'(count), 3);
    chk("R8 second eoc", int'(eoc), 1);

    // R4 pin clock
    pinIn = 1'b1;
    doReset();
    wr(2'd1, 8'h04);
    wr(2'd3, 8'd1 << 2);
    wr(2'd2, 8'd10);
    wr(2'd0, 8'h0C);
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R4 static pin", int'(count), 10);
    pinIn = 1'b0;
    repeat (2) @(negedge clk);
    chk("R4 latency", int'(count), 10);
    @(negedge clk);
    chk("R4 one step", int'(count), 9);
    pinIn = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 rising ignored", int'(count), 9);
    pinIn = 1'b0;
    repeat (3) @(negedge clk);
    pinIn = 1'b1;
    repeat (3) @(negedge clk);
    pinIn = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 three edges", int'(count), 7);

    // R5 gate
    pinIn = 1'b0;
    doReset();
    wr(2'd1, 8'h04);
    wr(2'd3, 8'd1 << 2);
    wr(2'd2, 8'd20);
    wr(2'd0, 8'h1C);
    @(negedge clk);
    repeat (5) @(negedge clk);
    chk("R5 gate closed", int'(count), 20);
    pinIn = 1'b1;
    repeat (6) @(negedge clk);
    pinIn = 1'b0;
    repeat (5) @(negedge clk);
    chk("R5 gate open six", int'(count), 14);

    // R9 one-shot trigger
    pinIn = 1'b1;
    doReset();
    wr(2'd1, 8'h04);
    wr(2'd3, 8'd1 << 2);
    wr(2'd2, 8'd8);
    wr(2'd0, 8'h2C);
    repeat (4) @(negedge clk);
    chk("R9 load bit ignored", int'(count), 0);
    pinIn = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 trigger load", int'(count), 8);
    pinIn = 1'b1;
    repeat (2) @(negedge clk);
    pinIn = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 retrigger ignored", int'(count), 3);
    pinIn = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 end", int'(count), 0);
    chk("R7 trigger eoc", int'(eoc), 1);
    repeat (4) @(negedge clk);
    chk("R9 stopped", int'(count), 0);
    pinIn = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 new trigger", int'(count), 8);

    // R10 restartable trigger
    pinIn = 1'b1;
    doReset();
    wr(2'd1, 8'h04);
    wr(2'd3, 8'd1 << 2);
    wr(2'd2, 8'd8);
    wr(2'd0, 8'h38);
    repeat (4) @(negedge clk);
    pinIn = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 first trigger", int'(count), 8);
    pinIn = 1'b1;
    repeat (2) @(negedge clk);
    pinIn = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 restart", int'(count), 8);
    pinIn = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 after restart", int'(count), 5);

    // R11 pin disabled, then internal source
    pinIn = 1'b0;
    doReset();
    wr(2'd1, 8'h06);
    wr(2'd3, 8'd1 << 2);
    wr(2'd2, 8'd30);
    wr(2'd0, 8'h0C);
    @(negedge clk);
    chk("R11 load", int'(count), 30);
    for (int k = 0; k < 10; k++) begin
      pinIn = ~pinIn;
      @(negedge clk);
    end
    chk("R11 pin disabled", int'(count), 20);
    pinIn = 1'b0;
    doReset();
    wr(2'd1, 8'h00);
    wr(2'd3, 8'd1 << 2);
    wr(2'd2, 8'd30);
    wr(2'd0, 8'h1C);
    @(negedge clk);
    repeat (10) @(negedge clk);
    chk("R11 internal source", int'(count), 20);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule